// File: doc/BRIEF.md
# MDIO Management Controller

This block is a register-driven master for the two-wire PHY management bus. A host sets up a control word that holds the clock divider and an enable flag. It then writes one command word that carries a start flag, a direction select, a PHY address, a register number and, for writes, the data. The controller sends a complete clause-22 management frame on MDC/MDIO. When the frame ends, the start flag clears itself.

For a read, the controller releases the data line at the turnaround. It samples whether the PHY pulls the line low, then shifts in sixteen data bits. The acknowledge result and the data are returned in the same command word. A 32-bit presence word records every PHY address that has acknowledged a read, so software can see which addresses are populated without scanning them again.

Register map (2-bit address): 0 is control, 1 is command, 2 is presence. Address 3 reads as zero.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (idle bit 31 set, enable bit 30 clear, divider 0). The command and presence words read 0. MDC is low and MDIO is not driven.
- R2: The command word fields are: GO at bit 31, write-select at bit 30 (1 = write), ACK at bit 29, register number at 25:21, PHY address at 20:16, data at 15:0. GO reads 1 while a frame is in flight and 0 after it ends. The control idle bit (bit 31) reads the inverse of GO.
- R3: Each frame is sent MSB first, as 64 bits in this order: 32 ones, start bits 01, opcode (10 for a read, 01 for a write), 5 PHY address bits, 5 register bits, turnaround (10 on a write), 16 data bits. MDIO changes only while MDC is low, so it is stable at every MDC rising edge.
- R4: With divider value D in control bits 7:0, the MDC period is E+1 host cycles, where E = D, or E = 1 when D = 0. A whole frame keeps GO set for 64·(E+1) host cycles.
- R5: On a read, MDIO output enable drops from the first turnaround bit to the end of the frame. The second turnaround bit is sampled on the MDC rising edge, and a low level sets ACK. The 16 data bits are captured on the rising edges into bits 15:0.
- R6: A read that no PHY drives low at the turnaround completes with ACK = 0.
- R7: An acknowledged read sets the presence bit indexed by its PHY address. No presence bit is ever cleared except by reset.
- R8: A command-word write that arrives while GO is set is ignored: it neither starts a frame nor alters any command field.
- R9: A command write with GO = 1 while the enable bit is 0 starts no frame. GO stays 0 and MDC stays low.
- R10: The divider is captured when a frame starts. Changing the control word during a frame does not change that frame's timing.
- R11: A write frame completes with ACK = 0, leaves the data field holding the written data, and does not change the presence word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 command, 2 presence |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (pulled high when released) |

## Verification
The hardest conditions to create are those that must land inside a frame: a command write while GO is set, and a divider change partway through a frame. Random transactions therefore inject those writes a few cycles after the start, then check that the command fields, frame duration and MDC period still match the original request. A bench PHY model decodes the address and opcode from the captured bits, so random addresses mix responding and silent PHYs. Directed runs cover divider 0 and 255 and the highest PHY address.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_PRES = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_GO_BIT   = 31;
  localparam int CMD_WR_BIT   = 30;
  localparam int CMD_ACK_BIT  = 29;
  localparam int CTRL_IDLE_BIT = 31;
  localparam int CTRL_EN_BIT  = 30;
  localparam int PREAMBLE_LEN = 32;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] eff_q, cnt_q;
  logic [DIV_W:0]   half;

  assign half = ({1'b0, eff_q} + 1'b1) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (start_i) begin
      eff_q <= (div_i == '0) ? DIV_W'(1) : div_i;  // divider latched per frame
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= (cnt_q == eff_q) ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign rise_o = run_i && ({1'b0, cnt_q} == half - 1'b1);
  assign fall_o = run_i && (cnt_q == eff_q);
  assign mdc_o  = run_i && ({1'b0, cnt_q} >= half);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  import mdio_pkg::*;
  localparam int TA_POS = PREAMBLE_LEN + 4 + PHY_W + REG_W;
  localparam int D_POS  = TA_POS + 2;
  localparam int NBITS  = D_POS + DATA_W;
  localparam int IW     = $clog2(NBITS);
  localparam logic [IW-1:0] TA_I   = IW'(TA_POS);
  localparam logic [IW-1:0] TA2_I  = IW'(TA_POS + 1);
  localparam logic [IW-1:0] D_I    = IW'(D_POS);
  localparam logic [IW-1:0] LAST_I = IW'(NBITS - 1);

  logic [NBITS-1:0]  sr_q;
  logic [IW-1:0]     idx_q;
  logic              busy_q, rd_q, ack_q;
  logic [DATA_W-1:0] rdat_q;
  logic              last;

  assign last = (idx_q == LAST_I);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else if (start_i) begin
      sr_q   <= {{PREAMBLE_LEN{1'b1}}, 2'b01, (wr_i ? 2'b01 : 2'b10), phy_i, reg_i,
                 2'b10, (wr_i ? data_i : {DATA_W{1'b0}})};
      idx_q  <= '0;
      busy_q <= 1'b1;
      rd_q   <= !wr_i;
      ack_q  <= 1'b0;
    end else if (busy_q) begin
      if (rise_i && rd_q) begin
        if (idx_q == TA2_I) ack_q <= !mdio_i;
        if (idx_q >= D_I)   rdat_q <= {rdat_q[DATA_W-2:0], mdio_i};
      end
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sr_q  <= sr_q << 1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && last;
  assign mdio_o    = sr_q[NBITS-1];
  assign mdio_oe_o = busy_q && !(rd_q && idx_q >= TA_I);
  assign ack_o     = ack_q;
  assign rdata_o   = rdat_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W  = 8,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  import mdio_pkg::*;
  localparam int NPHY    = 1 << PHY_W;
  localparam int PHY_LSB = DATA_W;
  localparam int REG_LSB = DATA_W + PHY_W;
  localparam int PAD_CMD = CMD_ACK_BIT - REG_LSB - REG_W;
  localparam int PAD_CTL = CTRL_EN_BIT - DIV_W;

  logic [DIV_W-1:0]  div_q;
  logic              en_q, wr_q, ack_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] data_q;
  logic [NPHY-1:0]   pres_q;

  logic busy, done, s_ack, rise, fall, cmd_we, start;
  logic [DATA_W-1:0] s_rdata;
  reg_sel_e sel;

  assign sel    = reg_sel_e'(reg_addr_i);
  assign cmd_we = reg_we_i && (sel == SEL_CMD) && !busy;
  assign start  = cmd_we && reg_wdata_i[CMD_GO_BIT] && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      en_q   <= 1'b0;
      wr_q   <= 1'b0;
      ack_q  <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
      pres_q <= '0;
    end else begin
      if (reg_we_i && sel == SEL_CTRL) begin
        div_q <= reg_wdata_i[DIV_W-1:0];
        en_q  <= reg_wdata_i[CTRL_EN_BIT];
      end
      if (cmd_we) begin
        wr_q   <= reg_wdata_i[CMD_WR_BIT];
        ack_q  <= 1'b0;
        reg_q  <= reg_wdata_i[REG_LSB +: REG_W];
        phy_q  <= reg_wdata_i[PHY_LSB +: PHY_W];
        data_q <= reg_wdata_i[DATA_W-1:0];
      end else if (done && !wr_q) begin
        ack_q  <= s_ack;
        data_q <= s_rdata;
        if (s_ack) pres_q[phy_q] <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: reg_rdata_o = {!busy, en_q, {PAD_CTL{1'b0}}, div_q};
      SEL_CMD:  reg_rdata_o = {busy, wr_q, ack_q, {PAD_CMD{1'b0}}, reg_q, phy_q, data_q};
      SEL_PRES: reg_rdata_o = 32'(pres_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .run_i  (busy),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_shf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .wr_i     (reg_wdata_i[CMD_WR_BIT]),
    .phy_i    (reg_wdata_i[PHY_LSB +: PHY_W]),
    .reg_i    (reg_wdata_i[REG_LSB +: REG_W]),
    .data_i   (reg_wdata_i[DATA_W-1:0]),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .busy_o   (busy),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .done_o   (done),
    .ack_o    (s_ack),
    .rdata_o  (s_rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        oe_i,
  input logic        busy_i,
  input logic        wr_i,
  input logic [4:0]  phy_i,
  input logic [4:0]  reg_i,
  input logic [31:0] pres_i
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !oe_i));

  a_r3_mdio_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> $stable(mdio_i));

  a_r5_release_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(oe_i) && busy_i) |-> !wr_i);

  a_r8_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(phy_i) && $stable(reg_i) && $stable(wr_i)));

  a_r7_presence_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pres_i & $past(pres_i)) == $past(pres_i)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .mdc_i (mdc_o),
  .mdio_i(mdio_o),
  .oe_i  (mdio_oe_o),
  .busy_i(busy),
  .wr_i  (wr_q),
  .phy_i (phy_q),
  .reg_i (reg_q),
  .pres_i(32'(pres_q))
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, oe;
  logic        mdi = 1'b1;

  int checks = 0, fails = 0;
  int rises = 0;
  longint cyc = 0;
  longint rise_t0 = 0, rise_t1 = 0;
  logic [63:0] cap = '0, capoe = '0;
  logic [31:0] present = 32'h8000_8421;
  logic [31:0] exp_pres = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_master uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(oe), .mdio_i(mdi)
  );

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'(p + r + 5'd7)};
  endfunction

  // PHY model: samples on MDC rise, drives after MDC fall
  always @(posedge mdc) begin
    if (rises < 64) begin
      cap[63-rises]   = mdo;
      capoe[63-rises] = oe;
    end
    if (rises == 0) rise_t0 = cyc;
    if (rises == 1) rise_t1 = cyc;
    rises++;
  end

  always @(negedge mdc) begin
    logic resp;
    resp = (cap[29:28] == 2'b10) && present[cap[27:23]];
    if (resp && rises == 47)                 mdi = 1'b0;
    else if (resp && rises >= 48 && rises < 64) mdi = phy_val(cap[27:23], cap[22:18])[63-rises];
    else                                     mdi = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic txn(input bit wr, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] d, input logic [7:0] div,
                     input bit inject, input bit chdiv);
    int eff, n;
    logic [31:0] v;
    logic [63:0] ef, eo;
    bit acked;
    eff = (div == 0) ? 1 : int'(div);
    reg_write(2'd0, {1'b0, 1'b1, 22'b0, div});
    rises = 0; cap = '0; capoe = '0;
    reg_write(2'd1, {1'b1, wr, 1'b0, 3'b0, r, p, d});
    n = 0;
    forever begin
      if (inject && n == 3) begin
        reg_write(2'd1, {1'b1, ~wr, 1'b0, 3'b0, ~r, ~p, ~d});
        n++;
      end else if (chdiv && n == 5) begin
        reg_write(2'd0, {1'b0, 1'b1, 22'b0, div + 8'd3});
        n++;
      end else begin
        reg_read(2'd1, v);
        if (!v[31] || n > 20000) break;
        n++;
        @(negedge clk);
      end
    end
    chk(n == 64 * (eff + 1), "R4/R10 frame length", 64'(n), 64'(64 * (eff + 1)));
    chk(rise_t1 - rise_t0 == longint'(eff + 1), "R4/R10 mdc period",
        64'(rise_t1 - rise_t0), 64'(eff + 1));
    acked = !wr && present[p];
    reg_read(2'd1, v);
    if (wr)
      chk(v == {3'b010, 3'b0, r, p, d}, "R11/R8 write readback", 64'(v), 64'({3'b010, 3'b0, r, p, d}));
    else if (acked)
      chk(v == {3'b001, 3'b0, r, p, phy_val(p, r)}, "R5/R2 read ack data", 64'(v),
          64'({3'b001, 3'b0, r, p, phy_val(p, r)}));
    else
      chk(v[31:16] == {3'b000, 3'b0, r, p}, "R6/R8 read nack", 64'(v[31:16]), 64'({3'b000, 3'b0, r, p}));
    reg_read(2'd0, v);
    chk(v[31] == 1'b1, "R2 idle after frame", 64'(v[31]), 64'd1);
    ef = wr ? {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d}
            : {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'b0};
    eo = wr ? '1 : {{46{1'b1}}, 18'b0};
    chk(capoe == eo, "R5 output enable pattern", capoe, eo);
    chk(((cap ^ ef) & eo) == '0, "R3 frame bits", cap & eo, ef & eo);
    if (acked) exp_pres[p] = 1'b1;
    reg_read(2'd2, v);
    chk(v == exp_pres, "R7 presence", 64'(v), 64'(exp_pres));
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd0, v); chk(v == 32'h8000_0000, "R1 reset control", 64'(v), 64'h8000_0000);
    reg_read(2'd1, v); chk(v == 32'h0, "R1 reset command", 64'(v), 64'h0);
    reg_read(2'd2, v); chk(v == 32'h0, "R1 reset presence", 64'(v), 64'h0);
    chk(!mdc && !oe, "R1 reset pins", {62'b0, mdc, oe}, 64'h0);

    // R9: disabled controller ignores GO
    reg_write(2'd0, {1'b0, 1'b0, 22'b0, 8'd2});
    rises = 0;
    reg_write(2'd1, {1'b1, 1'b0, 1'b0, 3'b0, 5'd3, 5'd0, 16'h0});
    repeat (30) @(negedge clk);
    reg_read(2'd1, v); chk(v[31] == 1'b0, "R9 GO not set when disabled", 64'(v[31]), 64'd0);
    reg_read(2'd0, v); chk(v[31] == 1'b1, "R9 idle when disabled", 64'(v[31]), 64'd1);
    chk(rises == 0, "R9 no MDC activity", 64'(rises), 64'd0);

    // directed corners
    txn(1'b0, 5'd31, 5'd2, 16'h0, 8'd0, 1'b0, 1'b0);
    txn(1'b0, 5'd7, 5'd1, 16'h0, 8'd1, 1'b1, 1'b0);
    txn(1'b1, 5'd31, 5'd4, 16'hA5C3, 8'd2, 1'b1, 1'b1);
    txn(1'b0, 5'd0, 5'd31, 16'h0, 8'd255, 1'b0, 1'b1);
    txn(1'b1, 5'd20, 5'd9, 16'hFFFF, 8'd3, 1'b0, 1'b0);

    for (int i = 0; i < 24; i++) begin
      logic [4:0] p;
      logic [1:0] pick;
      pick = 2'($urandom % 4);
      p = ($urandom % 4 == 0) ? 5'($urandom % 32) : 5'(pick * 5);
      txn(1'($urandom % 2), p, 5'($urandom % 32), 16'($urandom),
          8'($urandom % 6), ($urandom % 3 == 0), ($urandom % 3 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule